// File: doc/BRIEF.md
# Debug Trigger Configuration Register Bank

This block holds the configuration of a small set of hardware debug triggers for a 32-bit core. Each trigger owns three words: a control word, a compare value and a context word. Software reaches them only indirectly. It first writes a trigger index into a select register. The three data addresses then read and write the words of the selected trigger. A fixed capability word reports which trigger kinds exist, and a machine context register holds the value that the context word of a trigger can be compared against.

Every write is legalized field by field before it is stored. The kind field of the control word cannot be changed. The debug-ownership bit is never set. Control fields that are not implemented are dropped. The context selector is squeezed to one of two legal values. Because of this, a read always returns a value the match logic can act on without further checks. The stored words of every trigger are exported in flat vectors so that the address comparators can use them directly. Decoding of the core's CSR numbers and the checks on access privilege belong to the surrounding core.

Top module: `dbg_trig_bank`

## Requirements
- R1: A write to the select register (address 0) with a value below NUM_TRIG makes that value the current index. A write with a value equal to or above NUM_TRIG leaves the index unchanged. Reading address 0 returns the index, zero-extended.
- R2: In the control word (address 1), bits 31:28 always read 2, whatever was written, and bit 27 always reads 0.
- R3: A control-word write keeps only these bits as written: bits 17:16 (access size; all four codes are legal in 32-bit mode), bit 6 (machine), bit 4 (supervisor), bit 3 (user), bit 2 (execute), bit 1 (store) and bit 0 (load). Bits 26:18, 15:7 and 5 always read 0.
- R4: The compare value (address 2) stores all 32 written bits for the selected trigger.
- R5: In the context word (address 3), bits 31:26 are stored as written. The selector field in bits 25:23 is stored as 0 when the written value is 0 to 3, and as 4 when it is 4 to 7. Bits 22:0 always read 0.
- R6: The capability word (address 4) always reads 32'h0000_0044, which means kinds 2 and 6 are supported. Writes to it have no effect.
- R7: After reset the index is 0, every control word reads 32'h2000_0000, and every compare value, every context word and the machine context register read 0.
- R8: The machine context register (address 5) stores bits 5:0 of a write. Its bits 31:6 read 0.
- R9: A read returns its value in the same cycle as the read strobe. csr_rdata is 0 while csr_rd is low, and for addresses 6 and 7. Writes to addresses 6 and 7 change nothing.
- R10: A write through addresses 1 to 3 changes only the words of the currently selected trigger.
- R11: The words of trigger i appear on bits [32*i+31:32*i] of trig_ctrl_o, trig_cmp_o and trig_ctx_o. The machine context appears on mctx_o. All of these equal the values a read would return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_addr | input | 3 | Register address: 0 select, 1 control, 2 compare, 3 context, 4 capability, 5 machine context |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, same cycle as csr_rd |
| trig_ctrl_o | output | 32*NUM_TRIG | Control word of every trigger |
| trig_cmp_o | output | 32*NUM_TRIG | Compare value of every trigger |
| trig_ctx_o | output | 32*NUM_TRIG | Context word of every trigger |
| mctx_o | output | 6 | Machine context value |

## Verification
A wrong index shows up on the very next read of addresses 1 to 3. It also shows up later, when a write lands on the wrong slice of the exported vectors. A field that was legalized wrongly becomes visible on the first read after the write, because reads are combinational. The bench therefore reads back a random address after every random write and compares the result against a model. A write that leaks into another trigger is caught at the end, when all exported slices are compared with the model.

// File: rtl/dbg_trig_pkg.sv
// Shared constants, address codes and legalization functions for the
// debug trigger register bank. Assumes a 32-bit data path.
package dbg_trig_pkg;

    localparam int XLEN   = 32;
    localparam int MCTX_W = 6;

    typedef enum logic [2:0] {
        A_SELECT = 3'd0,
        A_CTRL   = 3'd1,
        A_CMP    = 3'd2,
        A_CTX    = 3'd3,
        A_INFO   = 3'd4,
        A_MCTX   = 3'd5
    } csr_addr_e;

    localparam logic [3:0]      KIND_ADDR_MATCH = 4'd2;
    localparam logic [3:0]      KIND_ADDR_MATCH_V6 = 4'd6;
    // bits kept from a control write: size 17:16, M 6, S 4, U 3, X 2, W 1, R 0
    localparam logic [XLEN-1:0] CTRL_KEEP  = 32'h0003_005F;
    localparam logic [XLEN-1:0] CTRL_RESET = {KIND_ADDR_MATCH, 28'h0};
    // context: value 31:26 kept; selector top bit 25 kept so 0..3 -> 0, 4..7 -> 4
    localparam logic [XLEN-1:0] CTX_KEEP   = 32'hFE00_0000;
    localparam logic [XLEN-1:0] INFO_VALUE =
        (XLEN'(1) << KIND_ADDR_MATCH) | (XLEN'(1) << KIND_ADDR_MATCH_V6);

    function automatic logic [XLEN-1:0] legal_ctrl(input logic [XLEN-1:0] w);
        return CTRL_RESET | (w & CTRL_KEEP);
    endfunction

    function automatic logic [XLEN-1:0] legal_ctx(input logic [XLEN-1:0] w);
        return w & CTX_KEEP;
    endfunction

endpackage

// File: rtl/dbg_trig_select.sv
// Trigger index register. It accepts a write only when the value names an
// implemented trigger. Otherwise the previous index is kept.
// Assumes wr_en is already qualified by the select address.
module dbg_trig_select #(
    parameter int NUM_TRIG = 2,
    parameter int IDX_W    = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [dbg_trig_pkg::XLEN-1:0] wdata,
    output logic [IDX_W-1:0]              sel_o
);
    logic [IDX_W-1:0] sel_q;
    logic             in_range;

    // range check of the requested index
    always_comb in_range = (wdata < dbg_trig_pkg::XLEN'(NUM_TRIG));

    // index register with ignored out-of-range writes
    always_ff @(posedge clk) begin
        if (!rst_n)                 sel_q <= '0;
        else if (wr_en && in_range) sel_q <= wdata[IDX_W-1:0];
    end

    assign sel_o = sel_q;

    // R1
    sel_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata >= dbg_trig_pkg::XLEN'(NUM_TRIG)) |=> $stable(sel_q));
    // R1
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sel_q) < NUM_TRIG);
endmodule

// File: rtl/dbg_trig_slot.sv
// Storage for one trigger: control, compare and context words. Writes are
// legalized before storage. Assumes the write strobes are already
// qualified by the selected index.
module dbg_trig_slot (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_ctrl,
    input  logic                          wr_cmp,
    input  logic                          wr_ctx,
    input  logic [dbg_trig_pkg::XLEN-1:0] wdata,
    output logic [dbg_trig_pkg::XLEN-1:0] ctrl_o,
    output logic [dbg_trig_pkg::XLEN-1:0] cmp_o,
    output logic [dbg_trig_pkg::XLEN-1:0] ctx_o
);
    import dbg_trig_pkg::*;

    logic [XLEN-1:0] ctrl_q, cmp_q, ctx_q;

    // control word, legalized on write
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_RESET;
        else if (wr_ctrl) ctrl_q <= legal_ctrl(wdata);
    end

    // compare value, stored as written
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (wr_cmp) cmp_q <= wdata;
    end

    // context word, selector squeezed to 0 or 4
    always_ff @(posedge clk) begin
        if (!rst_n)      ctx_q <= '0;
        else if (wr_ctx) ctx_q <= legal_ctx(wdata);
    end

    assign ctrl_o = ctrl_q;
    assign cmp_o  = cmp_q;
    assign ctx_o  = ctx_q;

    // R2
    kind_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctrl_q[31:27] == 5'b00100));
    // R3
    ctrl_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ((ctrl_q & ~CTRL_KEEP) == CTRL_RESET));
    // R5
    ctx_selector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctx |=> (ctx_q[24:0] == 25'd0 && ctx_q[25] == $past(wdata[25])));
    // R4
    cmp_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmp |=> (cmp_q == $past(wdata)));
    // R10
    slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ctrl || wr_cmp || wr_ctx) |=>
            ($stable(ctrl_q) && $stable(cmp_q) && $stable(ctx_q)));
endmodule

// File: rtl/dbg_trig_rdmux.sv
// Combinational read path. Picks the addressed word of the selected
// trigger, or a global register. Returns zero when no read is strobed.
// Assumes sel is below NUM_TRIG.
module dbg_trig_rdmux #(
    parameter int NUM_TRIG = 2,
    parameter int IDX_W    = 1
) (
    input  logic                                   rd_en,
    input  logic [2:0]                             addr,
    input  logic [IDX_W-1:0]                       sel,
    input  logic [NUM_TRIG*dbg_trig_pkg::XLEN-1:0] ctrl_flat,
    input  logic [NUM_TRIG*dbg_trig_pkg::XLEN-1:0] cmp_flat,
    input  logic [NUM_TRIG*dbg_trig_pkg::XLEN-1:0] ctx_flat,
    input  logic [dbg_trig_pkg::MCTX_W-1:0]        mctx,
    output logic [dbg_trig_pkg::XLEN-1:0]          rdata
);
    import dbg_trig_pkg::*;

    localparam int SEL_PAD = XLEN - IDX_W;
    localparam int CTX_PAD = XLEN - MCTX_W;

    int base;

    // word selection by address and trigger index
    always_comb begin
        base  = int'(sel) * XLEN;
        rdata = '0;
        if (rd_en) begin
            case (csr_addr_e'(addr))
                A_SELECT: rdata = {{SEL_PAD{1'b0}}, sel};
                A_CTRL:   rdata = ctrl_flat[base +: XLEN];
                A_CMP:    rdata = cmp_flat[base +: XLEN];
                A_CTX:    rdata = ctx_flat[base +: XLEN];
                A_INFO:   rdata = INFO_VALUE;
                A_MCTX:   rdata = {{CTX_PAD{1'b0}}, mctx};
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dbg_trig_bank.sv
// Debug trigger register bank. It decodes the write address, holds the
// index register and the machine context, keeps one storage slot per
// trigger and exports all stored words. Assumes a single-cycle CSR
// access strobe from the core.
module dbg_trig_bank #(
    parameter int NUM_TRIG = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   csr_rd,
    input  logic                   csr_wr,
    input  logic [2:0]             csr_addr,
    input  logic [31:0]            csr_wdata,
    output logic [31:0]            csr_rdata,
    output logic [NUM_TRIG*32-1:0] trig_ctrl_o,
    output logic [NUM_TRIG*32-1:0] trig_cmp_o,
    output logic [NUM_TRIG*32-1:0] trig_ctx_o,
    output logic [5:0]             mctx_o
);
    import dbg_trig_pkg::*;

    localparam int IDX_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

    logic [IDX_W-1:0]  sel;
    logic              wr_sel, wr_ctrl, wr_cmp, wr_ctx, wr_mctx;
    logic [MCTX_W-1:0] mctx_q;

    // write strobe decode by address
    always_comb begin
        wr_sel  = csr_wr && (csr_addr == A_SELECT);
        wr_ctrl = csr_wr && (csr_addr == A_CTRL);
        wr_cmp  = csr_wr && (csr_addr == A_CMP);
        wr_ctx  = csr_wr && (csr_addr == A_CTX);
        wr_mctx = csr_wr && (csr_addr == A_MCTX);
    end

    // machine context register, low bits only
    always_ff @(posedge clk) begin
        if (!rst_n)       mctx_q <= '0;
        else if (wr_mctx) mctx_q <= csr_wdata[MCTX_W-1:0];
    end

    assign mctx_o = mctx_q;

    dbg_trig_select #(.NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) u_select (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_sel),
        .wdata (csr_wdata),
        .sel_o (sel)
    );

    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_slot
        logic hit;
        assign hit = (int'(sel) == i);
        dbg_trig_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (wr_ctrl && hit),
            .wr_cmp  (wr_cmp && hit),
            .wr_ctx  (wr_ctx && hit),
            .wdata   (csr_wdata),
            .ctrl_o  (trig_ctrl_o[i*XLEN +: XLEN]),
            .cmp_o   (trig_cmp_o[i*XLEN +: XLEN]),
            .ctx_o   (trig_ctx_o[i*XLEN +: XLEN])
        );
    end

    dbg_trig_rdmux #(.NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) u_rdmux (
        .rd_en     (csr_rd),
        .addr      (csr_addr),
        .sel       (sel),
        .ctrl_flat (trig_ctrl_o),
        .cmp_flat  (trig_cmp_o),
        .ctx_flat  (trig_ctx_o),
        .mctx      (mctx_q),
        .rdata     (csr_rdata)
    );

    // R6
    info_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd && csr_addr == 3'd4) |-> (csr_rdata == 32'h0000_0044));
    // R8
    mctx_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mctx |=> (mctx_o == $past(csr_wdata[5:0])));
    // R9
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rd |-> (csr_rdata == 32'd0));
endmodule

// File: tb/dbg_trig_bank_test.sv
module dbg_trig_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              csr_rd = 1'b0, csr_wr = 1'b0;
    logic [2:0]        csr_addr = '0;
    logic [31:0]       csr_wdata = '0;
    logic [31:0]       csr_rdata;
    logic [NT*32-1:0]  trig_ctrl_o, trig_cmp_o, trig_ctx_o;
    logic [5:0]        mctx_o;

    int total = 0, bad = 0;
    bit done = 1'b0;

    // reference model
    int          m_sel;
    logic [31:0] m_c1 [NT];
    logic [31:0] m_c2 [NT];
    logic [31:0] m_c3 [NT];
    logic [5:0]  m_mctx;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_trig_bank #(.NUM_TRIG(NT)) uut (
        .clk(clk), .rst_n(rst_n), .csr_rd(csr_rd), .csr_wr(csr_wr),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .trig_ctrl_o(trig_ctrl_o), .trig_cmp_o(trig_cmp_o),
        .trig_ctx_o(trig_ctx_o), .mctx_o(mctx_o)
    );

    function automatic logic [31:0] exp_ctrl(input logic [31:0] w);
        return 32'h2000_0000 | (w & 32'h0003_005F);
    endfunction

    function automatic logic [31:0] exp_ctx(input logic [31:0] w);
        logic [31:0] r;
        r = {w[31:26], 26'd0};
        if (w[25:23] >= 3'd4) r[25:23] = 3'd4;
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        case (a)
            0: return 32'(m_sel);
            1: return m_c1[m_sel];
            2: return m_c2[m_sel];
            3: return m_c3[m_sel];
            4: return 32'h44;
            5: return {26'd0, m_mctx};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R1";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_sel = 0; m_mctx = '0;
        for (int i = 0; i < NT; i++) begin
            m_c1[i] = 32'h2000_0000; m_c2[i] = '0; m_c3[i] = '0;
        end
    endtask

    task automatic model_write(input int a, input logic [31:0] d);
        case (a)
            0: if (d < 32'(NT)) m_sel = int'(d);
            1: m_c1[m_sel] = exp_ctrl(d);
            2: m_c2[m_sel] = d;
            3: m_c3[m_sel] = exp_ctx(d);
            5: m_mctx = d[5:0];
            default: ;
        endcase
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = 3'(a); csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_check(input int a, input string tag);
        @(negedge clk);
        csr_rd = 1'b1; csr_addr = 3'(a);
        #1;
        check(tag, csr_rdata, exp_read(a));
        csr_rd = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int a;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R7 reset state of every register
        for (int t = 0; t < NT; t++) begin
            wr(0, 32'(t));
            rd_check(0, "R7");
            rd_check(1, "R7");
            rd_check(2, "R7");
            rd_check(3, "R7");
        end
        rd_check(5, "R7");

        // R1 out-of-range selects are ignored
        wr(0, 32'd1);
        wr(0, 32'(NT)); rd_check(0, "R1");
        wr(0, 32'hFFFF_FFFF); rd_check(0, "R1");
        wr(0, 32'd0); rd_check(0, "R1");

        // R2 kind and ownership bit cannot be written; R3 dropped bits
        wr(1, 32'hFFFF_FFFF); rd_check(1, "R2");
        wr(1, 32'h6800_0000); rd_check(1, "R2");
        wr(1, 32'h0002_0045); rd_check(1, "R3");

        // R5 selector squeeze for each value
        for (int s = 0; s < 8; s++) begin
            wr(3, {6'h2A, 3'(s), 23'h7F_FFFF});
            rd_check(3, "R5");
        end

        // R4 full compare value
        wr(2, 32'hDEAD_BEEF); rd_check(2, "R4");

        // R6 capability word unaffected by writes
        wr(4, 32'h1234_5678); rd_check(4, "R6");

        // R8 machine context width
        wr(5, 32'hFFFF_FFC5); rd_check(5, "R8");

        // R9 idle read and unused addresses
        wr(6, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
        rd_check(6, "R9"); rd_check(7, "R9");
        @(negedge clk); csr_addr = 3'd2; #1;
        check("R9", csr_rdata, 32'd0);

        // R10 write to trigger 1 leaves trigger 0 alone
        wr(0, 32'd1); wr(2, 32'h0BAD_F00D); wr(1, 32'h0000_0007);
        wr(0, 32'd0); rd_check(2, "R10"); rd_check(1, "R10");

        // random mix
        for (int n = 0; n < 400; n++) begin
            a = int'($urandom % 8);
            d = $urandom;
            if (a == 0 && ($urandom % 4) != 0) d = $urandom % 4;
            wr(a, d);
            a = int'($urandom % 8);
            rd_check(a, tag_of(a));
        end

        // R11 exported vectors match the model
        @(negedge clk);
        for (int t = 0; t < NT; t++) begin
            check("R11", trig_ctrl_o[t*32 +: 32], m_c1[t]);
            check("R11", trig_cmp_o[t*32 +: 32], m_c2[t]);
            check("R11", trig_ctx_o[t*32 +: 32], m_c3[t]);
        end
        check("R11", {26'd0, mctx_o}, {26'd0, m_mctx});

        // R7 reset again after activity
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_reset();
        rd_check(0, "R7"); rd_check(1, "R7"); rd_check(3, "R7");
        check("R7", trig_cmp_o[63:32], 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule